// File: doc/BRIEF.md
# Calibrated Real-Time Clock Core

This block keeps wall-clock time as an unsigned 32-bit count of seconds. A slow tick enable, one pulse per crystal period, drives a sub-second prescaler. The prescaler's period comes from a calibration word. That word holds an integer tick count per second and a 4-bit fractional trim. When the trim is enabled, some seconds in every sixteen are made one tick longer, so long-term drift can be corrected in steps finer than one tick.

The seconds value is compared with an alarm register. The per-second event and the alarm event each set a sticky status bit. A mask register gates the status bits onto a single interrupt output. Software unmasks a bit through one write-one port and masks it through another. Software reaches all registers over a simple single-cycle register bus. Reads are combinational and writes take effect at the clock edge. Software handles any conversion between calendar dates and seconds.

Top module: `rtc_core`

## Requirements
- R1: After reset the seconds (0x10), tick (0x14), status (0x20) and control (0x40) registers read 0. Calibration readback (0x0C) reads 0x198233. The mask (0x24) reads 0x3, which means both interrupts are masked. The irq output is 0.
- R2: Control bit 24 (offset 0x40) enables the oscillator. While the bit is 0, tick pulses leave the tick counter and the seconds counter unchanged.
- R3: The calibration word is written at 0x08. Bits 15:0 give N, the number of ticks per second (N ≥ 1). Offset 0x14 shows the tick count, which runs 0..N-1 in its low 16 bits and returns to 0 at each second boundary.
- R4: When calibration bit 20 is 1 and bits 19:16 hold F, seconds are counted in a cycle of 16 that restarts at each calibration write. The first F seconds of each cycle last N+1 ticks and the rest last N ticks.
- R5: At each second boundary the seconds counter increments. After 0xFFFFFFFF it wraps to 0.
- R6: A write to 0x00 clears the tick counter at once. The written value replaces the seconds count at the next second boundary. Offset 0x04 returns the last value written to 0x00.
- R7: The alarm value is written at 0x18. Status bit 1 is set at the boundary where the new seconds value equals the alarm value.
- R8: Status bit 0 is set at every second boundary. Writing 1 to a status bit at 0x20 clears that bit. If the same bit's event occurs in the same cycle as the clear, the bit stays set.
- R9: Writing 1 to a bit at 0x28 clears that bit of the mask. Writing 1 to a bit at 0x2C sets it. Status bits are set whether or not they are masked.
- R10: irq equals the OR over all bits of status AND NOT mask.
- R11: Calibration writes keep only bits 20:0. Any offset that is not mapped reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_tick | input | 1 | One-cycle pulse per crystal period |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register byte offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data for addr |
| irq | output | 1 | Interrupt request, level |

## Verification
The assertions assume that osc_tick lasts one cycle and that the integer tick count in the calibration word is never 0. They also assume that writes to the status, enable and disable ports arrive as separate bus cycles. The stimulus programs only small non-zero tick counts, such as 4, so that many seconds pass in a short run. It drives at most one write per cycle, and it combines a tick with a write only in the one case that tests a clear racing with an event. A behavioural model runs every cycle and follows the same input rules.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam logic [7:0] OFS_SET_WR  = 8'h00;
  localparam logic [7:0] OFS_SET_RD  = 8'h04;
  localparam logic [7:0] OFS_CAL_WR  = 8'h08;
  localparam logic [7:0] OFS_CAL_RD  = 8'h0C;
  localparam logic [7:0] OFS_SECS    = 8'h10;
  localparam logic [7:0] OFS_TICK    = 8'h14;
  localparam logic [7:0] OFS_ALARM   = 8'h18;
  localparam logic [7:0] OFS_STS     = 8'h20;
  localparam logic [7:0] OFS_MASK    = 8'h24;
  localparam logic [7:0] OFS_UNMASK  = 8'h28;
  localparam logic [7:0] OFS_DOMASK  = 8'h2C;
  localparam logic [7:0] OFS_CTRL    = 8'h40;

  localparam int CNT_W   = 16;
  localparam int FRAC_W  = 4;
  localparam int CAL_W   = CNT_W + FRAC_W + 1;
  localparam int FEN_BIT = CNT_W + FRAC_W;
  localparam int OSC_BIT = 24;
  localparam int EVT_N   = 2;
  localparam int EVT_SEC = 0;
  localparam int EVT_ALM = 1;
  localparam logic [CAL_W-1:0] CAL_RST = 21'h198233;
endpackage

// File: rtl/rtc_prescale.sv
module rtc_prescale #(
  parameter int CNT_W  = 16,
  parameter int FRAC_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              restart,
  input  logic              cal_load,
  input  logic [CNT_W-1:0]  int_cnt,
  input  logic [FRAC_W-1:0] frac,
  input  logic              frac_en,
  output logic [CNT_W-1:0]  tick_q,
  output logic              boundary
);
  logic [CNT_W-1:0]  tick_d;
  logic [FRAC_W-1:0] phase_q, phase_d;
  logic [CNT_W:0]    term;
  logic              ext;

  always_comb begin
    ext      = frac_en && (phase_q < frac);
    term     = {1'b0, int_cnt} - 1'b1 + {{CNT_W{1'b0}}, ext};
    boundary = run && !restart && ({1'b0, tick_q} >= term);
    tick_d   = tick_q;
    if (restart)       tick_d = '0;
    else if (boundary) tick_d = '0;
    else if (run)      tick_d = tick_q + 1'b1;
    phase_d  = phase_q;
    if (cal_load)      phase_d = '0;
    else if (boundary) phase_d = phase_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q  <= '0;
      phase_q <= '0;
    end else begin
      tick_q  <= tick_d;
      phase_q <= phase_d;
    end
  end
endmodule

// File: rtl/rtc_seconds.sv
module rtc_seconds #(
  parameter int SEC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_wr,
  input  logic [SEC_W-1:0] set_val,
  input  logic             boundary,
  input  logic [SEC_W-1:0] alarm,
  output logic [SEC_W-1:0] sec_q,
  output logic             pend_q,
  output logic             alarm_hit
);
  logic [SEC_W-1:0] sec_nxt, sec_d;
  logic             pend_d;

  always_comb begin
    sec_nxt   = pend_q ? set_val : sec_q + 1'b1;
    alarm_hit = boundary && (sec_nxt == alarm);
    sec_d     = boundary ? sec_nxt : sec_q;
    pend_d    = pend_q;
    if (set_wr)        pend_d = 1'b1;
    else if (boundary) pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      sec_q  <= sec_d;
      pend_q <= pend_d;
    end
  end
endmodule

// File: rtl/rtc_irq.sv
module rtc_irq #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt,
  input  logic         clr_wr,
  input  logic         unmask_wr,
  input  logic         domask_wr,
  input  logic [N-1:0] wbits,
  output logic [N-1:0] sts_q,
  output logic [N-1:0] mask_q,
  output logic         irq
);
  logic [N-1:0] sts_d, mask_d;

  always_comb begin
    sts_d  = (sts_q & ~(clr_wr ? wbits : '0)) | evt;
    mask_d = mask_q;
    if (unmask_wr)      mask_d = mask_q & ~wbits;
    else if (domask_wr) mask_d = mask_q | wbits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q  <= '0;
      mask_q <= '1;
    end else begin
      sts_q  <= sts_d;
      mask_q <= mask_d;
    end
  end

  assign irq = |(sts_q & ~mask_q);
endmodule

// File: rtl/rtc_core.sv
module rtc_core
  import rtc_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              osc_tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  localparam int SEC_W = DATA_W;

  logic [CAL_W-1:0] cal_q, cal_d;
  logic             osc_q, osc_d;
  logic [SEC_W-1:0] set_q, set_d, alarm_q, alarm_d;
  logic             wr_set, wr_cal, wr_alm, wr_sts, wr_unm, wr_msk, wr_ctl;
  logic [CNT_W-1:0] tick_q;
  logic             boundary, alarm_hit, pend_q;
  logic [SEC_W-1:0] sec_q;
  logic [EVT_N-1:0] evt, sts_q, mask_q;

  always_comb begin
    wr_set = wr_en && (addr == OFS_SET_WR);
    wr_cal = wr_en && (addr == OFS_CAL_WR);
    wr_alm = wr_en && (addr == OFS_ALARM);
    wr_sts = wr_en && (addr == OFS_STS);
    wr_unm = wr_en && (addr == OFS_UNMASK);
    wr_msk = wr_en && (addr == OFS_DOMASK);
    wr_ctl = wr_en && (addr == OFS_CTRL);
    cal_d   = wr_cal ? wdata[CAL_W-1:0] : cal_q;
    osc_d   = wr_ctl ? wdata[OSC_BIT]   : osc_q;
    set_d   = wr_set ? wdata            : set_q;
    alarm_d = wr_alm ? wdata            : alarm_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cal_q   <= CAL_RST;
      osc_q   <= 1'b0;
      set_q   <= '0;
      alarm_q <= '0;
    end else begin
      cal_q   <= cal_d;
      osc_q   <= osc_d;
      set_q   <= set_d;
      alarm_q <= alarm_d;
    end
  end

  rtc_prescale #(.CNT_W(CNT_W), .FRAC_W(FRAC_W)) i_pre (
    .clk(clk), .rst_n(rst_n), .run(osc_q && osc_tick), .restart(wr_set),
    .cal_load(wr_cal), .int_cnt(cal_q[CNT_W-1:0]),
    .frac(cal_q[FEN_BIT-1:CNT_W]), .frac_en(cal_q[FEN_BIT]),
    .tick_q(tick_q), .boundary(boundary)
  );

  rtc_seconds #(.SEC_W(SEC_W)) i_sec (
    .clk(clk), .rst_n(rst_n), .set_wr(wr_set), .set_val(set_q),
    .boundary(boundary), .alarm(alarm_q), .sec_q(sec_q), .pend_q(pend_q),
    .alarm_hit(alarm_hit)
  );

  always_comb begin
    evt          = '0;
    evt[EVT_SEC] = boundary;
    evt[EVT_ALM] = alarm_hit;
  end

  rtc_irq #(.N(EVT_N)) i_irq (
    .clk(clk), .rst_n(rst_n), .evt(evt), .clr_wr(wr_sts), .unmask_wr(wr_unm),
    .domask_wr(wr_msk), .wbits(wdata[EVT_N-1:0]), .sts_q(sts_q),
    .mask_q(mask_q), .irq(irq)
  );

  always_comb begin
    rdata = '0;
    case (addr)
      OFS_SET_RD: rdata = set_q;
      OFS_CAL_RD: rdata[CAL_W-1:0] = cal_q;
      OFS_SECS:   rdata = sec_q;
      OFS_TICK:   rdata[CNT_W-1:0] = tick_q;
      OFS_ALARM:  rdata = alarm_q;
      OFS_STS:    rdata[EVT_N-1:0] = sts_q;
      OFS_MASK:   rdata[EVT_N-1:0] = mask_q;
      OFS_CTRL:   rdata[OSC_BIT] = osc_q;
      default:    rdata = '0;
    endcase
  end
endmodule

// File: rtl/rtc_core_chk.sv
module rtc_core_chk
  import rtc_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [7:0]       addr,
  input logic [31:0]      wdata,
  input logic             osc_q,
  input logic             boundary,
  input logic             pend_q,
  input logic [CNT_W-1:0] tick_q,
  input logic [31:0]      sec_q,
  input logic [EVT_N-1:0] sts_q,
  input logic [EVT_N-1:0] mask_q,
  input logic             irq
);
  // R2
  osc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!osc_q && !(wr_en && addr == OFS_SET_WR)) |=> $stable(tick_q));
  // R5
  sec_only_on_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !boundary |=> $stable(sec_q));
  // R5
  sec_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && !pend_q && sec_q == 32'hFFFF_FFFF) |=> (sec_q == 32'd0));
  // R3
  tick_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    boundary |=> (tick_q == '0));
  // R8
  sec_sts_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_q[EVT_SEC]) |-> $past(boundary));
  // R8
  sec_sts_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    boundary |=> sts_q[EVT_SEC]);
  // R9
  unmask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFS_UNMASK && wdata[EVT_ALM]) |=> !mask_q[EVT_ALM]);
  // R10
  irq_needs_sts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (sts_q != '0));
endmodule

bind rtc_core rtc_core_chk i_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .osc_q(osc_q), .boundary(boundary), .pend_q(pend_q), .tick_q(tick_q),
  .sec_q(sec_q), .sts_q(sts_q), .mask_q(mask_q), .irq(irq)
);

// File: tb/test_rtc_core.sv
module test_rtc_core;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        tk, wr;
  logic [7:0]  ad;
  logic [31:0] wd;
  logic [31:0] rdata;
  logic        irq;
  int checks = 0;
  int fails  = 0;
  bit live   = 0;

  always #2 clk = ~clk;

  rtc_core i_rtc_core (.clk(clk), .rst_n(rst_n), .osc_tick(tk), .wr_en(wr),
    .addr(ad), .wdata(wd), .rdata(rdata), .irq(irq));

  // behavioural reference model
  int          m_tick, m_ph;
  logic [31:0] m_sec, m_set, m_alm;
  logic [20:0] m_cal;
  logic        m_osc, m_pend;
  logic [1:0]  m_sts, m_mask;

  always @(posedge clk) begin : mdl
    int len;
    bit bnd, hit;
    logic [31:0] ns;
    if (!rst_n) begin
      m_tick = 0; m_ph = 0; m_sec = 0; m_set = 0; m_alm = 0;
      m_cal = 21'h198233; m_osc = 0; m_pend = 0; m_sts = 0; m_mask = 2'b11;
    end else begin
      bnd = 0; hit = 0;
      if (wr && ad == 8'h00) m_tick = 0;
      else if (m_osc && tk) begin
        len = int'(m_cal[15:0]) + ((m_cal[20] && m_ph < int'(m_cal[19:16])) ? 1 : 0);
        if (m_tick + 1 >= len) begin bnd = 1; m_tick = 0; m_ph = (m_ph + 1) % 16; end
        else m_tick = m_tick + 1;
      end
      if (bnd) begin
        ns = m_pend ? m_set : m_sec + 32'd1;
        hit = (ns == m_alm);
        m_sec = ns; m_pend = 0;
      end
      if (wr && ad == 8'h20) m_sts = m_sts & ~wd[1:0];
      if (bnd) m_sts[0] = 1'b1;
      if (hit) m_sts[1] = 1'b1;
      if (wr) case (ad)
        8'h00: begin m_set = wd; m_pend = 1; end
        8'h08: begin m_cal = wd[20:0]; m_ph = 0; end
        8'h18: m_alm = wd;
        8'h28: m_mask = m_mask & ~wd[1:0];
        8'h2C: m_mask = m_mask | wd[1:0];
        8'h40: m_osc = wd[24];
        default: ;
      endcase
    end
  end

  function automatic logic [31:0] mread(input logic [7:0] a);
    case (a)
      8'h04: return m_set;
      8'h0C: return {11'd0, m_cal};
      8'h10: return m_sec;
      8'h14: return m_tick;
      8'h18: return m_alm;
      8'h20: return {30'd0, m_sts};
      8'h24: return {30'd0, m_mask};
      8'h40: return {7'd0, m_osc, 24'd0};
      default: return 32'd0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (live && rst_n) chk("R10 irq vs model", {31'd0, irq}, {31'd0, |(m_sts & ~m_mask)});

  task automatic step(input bit t, input bit w, input logic [7:0] a, input logic [31:0] d);
    tk = t; wr = w; ad = a; wd = d;
    @(posedge clk); @(negedge clk);
    tk = 0; wr = 0; wd = 0;
  endtask
  task automatic wreg(input logic [7:0] a, input logic [31:0] d); step(0, 1, a, d); endtask
  task automatic ticks(input int n); for (int i = 0; i < n; i++) step(1, 0, 8'h00, 0); endtask
  task automatic rdx(input logic [7:0] a, input logic [31:0] e, input string tag);
    ad = a; #0.5; chk(tag, rdata, e); chk({tag, " model"}, rdata, mread(a));
  endtask
  task automatic rdm(input logic [7:0] a, input string tag);
    ad = a; #0.5; chk(tag, rdata, mread(a));
  endtask
  task automatic seclen(input int e, input string tag);
    int n = 0;
    bit done = 0;
    wreg(8'h20, 32'h1);
    while (!done && n < 64) begin
      ticks(1); n++;
      ad = 8'h20; #0.5; done = rdata[0];
    end
    chk(tag, n, e);
  endtask

  initial begin
    #200000;
    fails++; $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 0; tk = 0; wr = 0; ad = 0; wd = 0;
    repeat (3) @(negedge clk);
    rst_n = 1; live = 1;
    rdx(8'h10, 0, "R1 secs"); rdx(8'h14, 0, "R1 tick"); rdx(8'h0C, 32'h198233, "R1 cal");
    rdx(8'h24, 3, "R1 mask"); rdx(8'h20, 0, "R1 sts"); rdx(8'h40, 0, "R1 ctrl");
    chk("R1 irq", {31'd0, irq}, 0);
    ticks(5); rdx(8'h14, 0, "R2 tick held"); rdx(8'h10, 0, "R2 secs held");
    wreg(8'h08, 32'h4); wreg(8'h40, 32'h0100_0000); wreg(8'h00, 100);
    ticks(2); rdx(8'h14, 2, "R3 tick mid");
    ticks(2); rdx(8'h10, 100, "R6 load"); rdx(8'h14, 0, "R3 tick wrap"); rdx(8'h04, 100, "R6 readback");
    ticks(4); rdx(8'h10, 101, "R5 incr");
    rdx(8'h20, 1, "R8 sec sts"); chk("R9 masked irq", {31'd0, irq}, 0);
    wreg(8'h28, 1); chk("R10 irq on", {31'd0, irq}, 1);
    wreg(8'h20, 1); rdx(8'h20, 0, "R8 w1c");
    ticks(3); step(1, 1, 8'h20, 1); rdx(8'h20, 1, "R8 set beats clear");
    wreg(8'h2C, 1); rdx(8'h24, 3, "R9 domask");
    wreg(8'h00, 32'hFFFF_FFFF); ticks(4); rdx(8'h10, 32'hFFFF_FFFF, "R6 load max");
    ticks(4); rdx(8'h10, 0, "R5 wrap");
    wreg(8'h20, 3); wreg(8'h18, 2);
    ticks(4); rdx(8'h20, 1, "R7 no match");
    ticks(4); rdx(8'h20, 3, "R7 match"); chk("R9 sts while masked irq", {31'd0, irq}, 0);
    wreg(8'h28, 2); chk("R9 unmask alarm", {31'd0, irq}, 1); rdx(8'h24, 1, "R9 mask rd");
    wreg(8'h2C, 3); wreg(8'h20, 3);
    wreg(8'h08, 32'hFFF3_0004); rdx(8'h0C, 32'h0013_0004, "R11 cal mask");
    wreg(8'h00, 0);
    seclen(5, "R4 long1"); seclen(5, "R4 long2"); seclen(5, "R4 long3");
    seclen(4, "R4 short1"); seclen(4, "R4 short2");
    rdx(8'h30, 0, "R11 unmapped"); rdx(8'h1C, 0, "R11 unmapped2");
    wreg(8'h40, 0); rdm(8'h14, "R2 before"); ticks(6);
    rdm(8'h14, "R2 tick frozen"); rdm(8'h10, "R2 secs frozen");
    foreach (i_list[k]) rdm(i_list[k], "R5 final model compare");
    live = 0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  logic [7:0] i_list [9] = '{8'h04, 8'h0C, 8'h10, 8'h14, 8'h18, 8'h20, 8'h24, 8'h40, 8'h3C};
endmodule